// File: doc/BRIEF.md
# Command-Word MDIO Management Master

This block is a management-bus master for clause-22 PHY access. Software controls it through one 32-bit control and status word on a simple register interface. A single write packs the whole request: write data, register number, PHY address, the read or write selector, an enable bit and a start/busy bit. If the request is valid, the block runs one complete MDIO frame. It generates MDC from the system clock and drives MDIO through a separate output enable, so that an external tri-state pad can release the line.

Software starts a transaction by writing the word with both the busy and enable bits set. It then polls the same word until busy reads back clear. When a read finishes, the 16 bits captured from the PHY replace the low half of the word. Requests to a PHY address outside the supported range never reach the bus. While a frame is in flight, the word cannot be changed.

Top module: `mdio_cmd_master`

## Requirements
- R1: The control word layout is: bits [15:0] data, [20:16] register number, [25:21] PHY address, bit 27 read (1) or write (0), bit 30 enable, bit 31 busy; `reg_rdata` always presents this word, and after reset it reads 0 with MDC low and the MDIO output enable low.
- R2: A write while idle with bit 31 and bit 30 set and a PHY address below `NUM_PHYS` starts a frame, and busy reads 1 from the next cycle.
- R3: Each frame carries, MSB first on rising MDC edges, `PRE_BITS` ones, start 01, opcode 10 for read or 01 for write, 5 PHY address bits, 5 register bits, a 2-bit turnaround and 16 data bits; on a write the turnaround is driven as 10, the data is bits [15:0], and MDIO is driven for the whole frame.
- R4: On a read, the MDIO output enable is low for the turnaround and all 16 data bits. The line is sampled on rising MDC, and the 16 bits land in [15:0] when busy clears.
- R5: MDC stays low while idle. Each MDC phase lasts `MDC_HALF` clocks, so every frame has exactly `PRE_BITS`+32 rising MDC edges.
- R6: Busy clears exactly (`PRE_BITS`+32)·2·`MDC_HALF` clock edges after the edge that accepted the command, and the other fields keep their written values.
- R7: Any register write while busy is set is ignored, including one that lands on the very edge where busy clears.
- R8: A started request whose PHY address is `NUM_PHYS` or higher produces no MDC activity and leaves busy clear; if it was a read, [15:0] reads 0xFFFF.
- R9: A write with bit 30 clear starts no frame, whatever bit 31 holds; the word is stored with busy clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
The sharp collision is a software write on the same clock edge on which the frame's last falling MDC edge clears busy and, for a read, loads the captured data. The bench counts clocks from the accepting edge, presents a one-cycle write with different fields on exactly that edge, and then checks two things: busy is clear, and the word still holds the original fields and the read data. Another write lands halfway through a frame. A sweep over every PHY address, including invalid ones, several register numbers and both directions then shows that the next command is accepted normally.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int DATA_LSB = 0;
  localparam int REG_LSB  = 16;
  localparam int PHY_LSB  = 21;
  localparam int RD_BIT   = 27;
  localparam int EN_BIT   = 30;
  localparam int BUSY_BIT = 31;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_t;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int MDC_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(MDC_HALF + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick     = run && (cnt_q == LAST_CNT);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (cnt_q == LAST_CNT) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run)) |-> !mdc); // R5
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_cmd_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        running,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rdata
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int IW         = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] TA_IDX   = IW'(PRE_BITS + 14);
  localparam logic [IW-1:0] DATA_IDX = IW'(PRE_BITS + 16);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  eng_state_t            state_q;
  logic [IW-1:0]         idx_q;
  logic [IW-1:0]         idx_nx;
  logic [FRAME_BITS-1:0] sr_q;
  logic [FRAME_BITS-1:0] frame_w;
  logic                  rd_q;

  always_comb begin
    frame_w = {{PRE_BITS{1'b1}}, 2'b01, (cmd.rd ? 2'b10 : 2'b01),
               cmd.phy, cmd.regn, 2'b10, (cmd.rd ? 16'h0000 : cmd.wdata)};
  end

  assign idx_nx  = idx_q + 1'b1;
  assign running = (state_q == ENG_RUN);
  assign done    = running && fall_evt && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      sr_q    <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else if (!running) begin
      if (start) begin
        state_q <= ENG_RUN;
        idx_q   <= '0;
        sr_q    <= frame_w;
        rd_q    <= cmd.rd;
        mdio_o  <= frame_w[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_evt && rd_q && (idx_q >= DATA_IDX))
        rdata <= {rdata[14:0], mdio_i};
      if (fall_evt) begin
        if (idx_q == LAST_IDX) begin
          state_q <= ENG_IDLE;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx_q   <= idx_nx;
          sr_q    <= sr_q << 1;
          mdio_o  <= sr_q[FRAME_BITS-2];
          mdio_oe <= !(rd_q && (idx_nx >= TA_IDX));
        end
      end
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (running && rd_q && (idx_q >= TA_IDX)) |-> !mdio_oe); // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (running && !rd_q) |-> mdio_oe); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start |-> !running); // R7
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int NUM_PHYS = 5,
  parameter int MDC_HALF = 4,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0] ctrl_q;
  logic [31:0] ctrl_nx;
  logic        busy;
  logic        want;
  logic        addr_ok;
  logic        launch;
  logic        eng_run;
  logic        eng_done;
  logic        rise_evt;
  logic        fall_evt;
  logic [15:0] eng_rdata;
  mdio_cmd_t   cmd_w;

  assign busy    = ctrl_q[BUSY_BIT];
  assign addr_ok = (32'(reg_wdata[PHY_LSB +: 5]) < NUM_PHYS);
  assign want    = reg_wr && !busy && reg_wdata[BUSY_BIT] && reg_wdata[EN_BIT];
  assign launch  = want && addr_ok;

  always_comb begin
    cmd_w.rd    = reg_wdata[RD_BIT];
    cmd_w.phy   = reg_wdata[PHY_LSB +: 5];
    cmd_w.regn  = reg_wdata[REG_LSB +: 5];
    cmd_w.wdata = reg_wdata[DATA_LSB +: 16];
  end

  always_comb begin
    ctrl_nx           = reg_wdata;
    ctrl_nx[BUSY_BIT] = launch;
    if (want && !addr_ok && reg_wdata[RD_BIT])
      ctrl_nx[DATA_LSB +: 16] = 16'hFFFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (busy) begin
      if (eng_done) begin
        ctrl_q[BUSY_BIT] <= 1'b0;
        if (ctrl_q[RD_BIT])
          ctrl_q[DATA_LSB +: 16] <= eng_rdata;
      end
    end else if (reg_wr) begin
      ctrl_q <= ctrl_nx;
    end
  end

  assign reg_rdata = ctrl_q;

  mdio_clk_gen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (eng_run),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (launch),
    .cmd      (cmd_w),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .running  (eng_run),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (eng_done),
    .rdata    (eng_rdata)
  );

  AST_BUSY_TRACKS_FRAME: assert property (@(posedge clk) disable iff (rst)
    busy == eng_run); // R6
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> $stable(ctrl_q)); // R7
  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (rst)
    (want && !addr_ok) |=> (!busy && !eng_run)); // R8
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !busy && !reg_wdata[EN_BIT]) |=> !busy); // R9
endmodule

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;
  localparam int HALF   = 2;
  localparam int NPHY   = 5;
  localparam int FCYC   = 64 * 2 * HALF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int          nrise = 0;
  int          base = 0;
  logic [63:0] cap = '0;
  logic [63:0] oeh = '0;
  logic [15:0] resp = '0;

  always #10 clk = ~clk;

  mdio_cmd_master #(.NUM_PHYS(NPHY), .MDC_HALF(HALF), .PRE_BITS(32)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY model: records the line on every rising MDC and presents the next response bit
  always @(posedge mdc) begin
    int k;
    cap   <= {cap[62:0], (mdio_oe ? mdio_o : mdio_i)};
    oeh   <= {oeh[62:0], mdio_oe};
    nrise <= nrise + 1;
    k = nrise + 1 - base;
    if (k >= 48 && k < 64) mdio_i <= resp[63 - k];
    else                   mdio_i <= 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one valid command; poke >= 0 injects a one-cycle write that many cycles after acceptance
  task automatic run_cmd(input bit rd, input int phy, input int rg,
                         input logic [15:0] wd, input logic [15:0] rsp, input int poke);
    logic [31:0] word, expw;
    logic [63:0] expf;
    int cyc;
    resp = rsp;
    word = {1'b1, 1'b1, 2'b00, rd, 1'b0, phy[4:0], rg[4:0], wd};
    expw = {1'b0, 1'b1, 2'b00, rd, 1'b0, phy[4:0], rg[4:0], (rd ? rsp : wd)};
    expf = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy[4:0], rg[4:0],
            (rd ? 2'b11 : 2'b10), (rd ? rsp : wd)};
    @(negedge clk);
    base = nrise;
    reg_wr = 1'b1; reg_wdata = word;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    check(reg_rdata[31] === 1'b1, "R2 busy after start", 64'(reg_rdata[31]), 64'd1);
    cyc = 0;
    while (reg_rdata[31] === 1'b1 && cyc < 4 * FCYC) begin
      if (cyc == poke) begin
        reg_wr = 1'b1; reg_wdata = 32'hC9E7_5A5A;
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    reg_wr = 1'b0;
    check(cyc == FCYC, "R6 frame length", 64'(cyc), 64'(FCYC));
    check(reg_rdata === expw, (poke >= 0) ? "R7 write during busy ignored" :
          (rd ? "R4 read data in word" : "R1 word after write"), 64'(reg_rdata), 64'(expw));
    check((nrise - base) == 64, "R5 MDC rising edges per frame", 64'(nrise - base), 64'd64);
    check(rd ? (cap[63:18] === expf[63:18] && cap[15:0] === expf[15:0]) : (cap === expf),
          rd ? "R4 read frame bits" : "R3 write frame bits", cap, expf);
    check(oeh === (rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF),
          rd ? "R4 released during turnaround and data" : "R3 driven whole frame",
          oeh, rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF);
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R5 idle after frame",
          64'({mdc, mdio_oe}), 64'd0);
  endtask

  // Writes a word that must not start a frame
  task automatic no_start(input logic [31:0] word, input logic [31:0] expw, input string req);
    int r0;
    @(negedge clk);
    r0 = nrise;
    reg_wr = 1'b1; reg_wdata = word;
    @(negedge clk);
    reg_wr = 1'b0;
    check(reg_rdata === expw, req, 64'(reg_rdata), 64'(expw));
    repeat (3 * HALF + 4) @(negedge clk);
    check(nrise == r0 && mdc === 1'b0, req, 64'(nrise - r0), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(reg_rdata === 32'h0 && mdc === 1'b0 && mdio_oe === 1'b0,
          "R1 reset state", 64'({reg_rdata, mdc, mdio_oe}), 64'd0);

    for (int phy = 0; phy < 8; phy++) begin
      for (int ri = 0; ri < 4; ri++) begin
        for (int rd = 0; rd < 2; rd++) begin
          int rg;
          logic [15:0] wd, rsp;
          rg  = (ri == 0) ? 0 : (ri == 1) ? 5 : (ri == 2) ? 18 : 31;
          wd  = 16'(32'h3C96 + phy * 4099 + rg * 263);
          rsp = 16'(32'hA5C3 + phy * 1031 + rg * 77);
          if (phy < NPHY) begin
            run_cmd(rd[0], phy, rg, wd, rsp, -1);
          end else begin
            logic [31:0] w;
            w = {1'b1, 1'b1, 2'b00, rd[0], 1'b0, 5'(phy), 5'(rg), wd};
            no_start(w, {1'b0, w[30:16], (rd[0] ? 16'hFFFF : wd)},
                     "R8 invalid PHY address rejected");
          end
        end
      end
    end

    no_start({1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 5'd1, 5'd3, 16'h1234},
             {1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 5'd1, 5'd3, 16'h1234},
             "R9 enable clear starts nothing");
    no_start({1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 5'd2, 5'd4, 16'hBEEF},
             {1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 5'd2, 5'd4, 16'hBEEF},
             "R9 busy clear starts nothing");

    run_cmd(1'b0, 3, 9, 16'h7E81, 16'h0, FCYC / 2);
    run_cmd(1'b1, 4, 30, 16'h0, 16'hD00D, FCYC / 3);
    run_cmd(1'b1, 2, 17, 16'h0, 16'h8001, FCYC - 1);
    run_cmd(1'b0, 1, 6, 16'h4242, 16'h0, FCYC - 1);
    run_cmd(1'b1, 0, 1, 16'h0, 16'hFFFF, -1);
    run_cmd(1'b1, 4, 31, 16'h0, 16'h0000, -1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule